// File: doc/BRIEF.md
# Dominant Run-Length Guard

This block sits between each raw dominant source of a two-bus repeater and the repeater's combining logic. It has one channel for each of four sources: the local transmit line, the expansion transmit line and the two bus receiver results. Every channel passes its active-low input to its active-low output with no added delay, so ordinary bit traffic is unaffected. If a dominant level (logic 0) stays on a channel for longer than a limit set in clock cycles, that channel's output is forced recessive (logic 1). A stuck node therefore cannot block the bus for good.

The limit is set from two parameters: the clock frequency and the timeout in microseconds. The default is 25 ms at 125 MHz. A limit in that range leaves room for traffic down to about 1 kbit/s, where a legal run of dominant bits stays far below the limit. Each channel has its own counter. Each channel also raises a status bit for as long as its output is being overridden.

Top module: `dom_timeout_guard`

## Requirements
- R1: While `rst_n` is low, every `out_n` bit is 1 and every `tmo_flag` bit is 0. Reset also clears each channel's dominant-run count, so a run that was cut by reset starts counting again from zero.
- R2: A channel whose `in_n` bit is 1 (recessive) drives its `out_n` bit to 1 and its `tmo_flag` bit to 0 in the same cycle.
- R3: A channel whose `in_n` bit is 0 drives its `out_n` bit to 0 with no clock delay, as long as fewer than LIMIT consecutive rising clock edges have sampled that input at 0.
- R4: Once LIMIT consecutive rising edges have sampled a channel's input at 0 and the input is still 0, that channel's `out_n` bit is 1 and its `tmo_flag` bit is 1.
- R5: The run count saturates at LIMIT and does not wrap. The override and the flag therefore stay on for as long as the input stays dominant.
- R6: When the input returns to 1, the flag drops at once. One rising edge that samples the input at 1 clears the count, so the next dominant passes straight through and gets a full new window. If the input is dominant again before any edge has seen it recessive, the override stays in force.
- R7: The channels are independent. A run, an override or a clear on one channel never changes the output or flag of another channel.
- R8: LIMIT equals CLK_HZ × TIMEOUT_US / 1,000,000, rounded up to a whole cycle. For example, 1.5 MHz and 13 µs give 20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the run counters |
| rst_n | input | 1 | Asynchronous active-low reset; forces all outputs recessive |
| in_n | input | NUM_CH | Raw active-low dominant sources, one bit per channel |
| out_n | output | NUM_CH | Guarded active-low outputs to the repeater logic |
| tmo_flag | output | NUM_CH | High while the channel's output is overridden by a timeout |

## Verification
The data path from `in_n` to `out_n` has no register, so the pass-through and recessive results (R2, R3, R6 flag drop) are due in the same cycle as the input change. The bench samples these one time unit after driving the input, with no clock edge in between. The override (R4) is due just after the LIMIT-th rising edge that sees a dominant input. The count clear (R6) is due just after the first edge that sees a recessive input. The bench counts rising edges per table row and samples two time units after the last edge of the row, so every check lands on an exact edge count. Rows with a zero count sample before any edge, which checks the combinational paths and the case of a dominant input that returns before any edge has cleared the count.

// File: rtl/dg_pkg.sv
package dg_pkg;

  // Cycles in the timeout window, rounded up so the window never falls short.
  function automatic longint unsigned limit_cycles(longint unsigned clk_hz,
                                                   longint unsigned tmo_us);
    longint unsigned c;
    c = (clk_hz * tmo_us + 64'd999_999) / 64'd1_000_000;
    if (c == 0) c = 1;
    return c;
  endfunction

  // Counter width able to hold the saturating value itself.
  function automatic int count_width(longint unsigned lim);
    return $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/dg_run_counter.sv
module dg_run_counter #(
  parameter int unsigned CW    = 8,
  parameter longint unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dom,
  output logic expired
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (!dom)       run_q <= '0;
    else if (run_q != LIM_V) run_q <= run_q + 1'b1;
  end

  assign expired = (run_q == LIM_V);
endmodule

// File: rtl/dg_override.sv
module dg_override (
  input  logic rst_n,
  input  logic in_n,
  input  logic expired,
  output logic out_n,
  output logic forced
);
  assign forced = rst_n & expired & ~in_n;
  assign out_n  = in_n | forced | ~rst_n;
endmodule

// File: rtl/dg_channel.sv
module dg_channel #(
  parameter int unsigned CW    = 8,
  parameter longint unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_n,
  output logic out_n,
  output logic forced,
  output logic expired
);
  dg_run_counter #(.CW(CW), .LIMIT(LIMIT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .dom     (~in_n),
    .expired (expired)
  );

  dg_override u_ovr (
    .rst_n   (rst_n),
    .in_n    (in_n),
    .expired (expired),
    .out_n   (out_n),
    .forced  (forced)
  );
endmodule

// File: rtl/dom_timeout_guard.sv
module dom_timeout_guard #(
  parameter int unsigned NUM_CH = 4,
  parameter longint unsigned CLK_HZ = 125_000_000,
  parameter longint unsigned TIMEOUT_US = 25_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] in_n,
  output logic [NUM_CH-1:0] out_n,
  output logic [NUM_CH-1:0] tmo_flag
);
  localparam longint unsigned LIMIT_CYC = dg_pkg::limit_cycles(CLK_HZ, TIMEOUT_US);
  localparam int unsigned CW = dg_pkg::count_width(LIMIT_CYC);

  // Per-channel saturation state, brought out for the checker.
  logic [NUM_CH-1:0] chan_expired;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dg_channel #(.CW(CW), .LIMIT(LIMIT_CYC)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_n    (in_n[g]),
      .out_n   (out_n[g]),
      .forced  (tmo_flag[g]),
      .expired (chan_expired[g])
    );
  end
endmodule

// File: rtl/dg_guard_checker.sv
module dg_guard_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter longint unsigned CLK_HZ = 125_000_000,
  parameter longint unsigned TIMEOUT_US = 25_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] in_n,
  input logic [NUM_CH-1:0] out_n,
  input logic [NUM_CH-1:0] tmo_flag,
  input logic [NUM_CH-1:0] chan_expired
);
  localparam longint unsigned LIM = dg_pkg::limit_cycles(CLK_HZ, TIMEOUT_US);
  localparam int unsigned CW = dg_pkg::count_width(LIM);
  localparam logic [CW-1:0] LIM_V = CW'(LIM);

  always @(negedge clk) begin
    if (!rst_n) AST_RESET_QUIET: assert (out_n == '1 && tmo_flag == '0); // R1
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic [CW-1:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          seen_q <= '0;
      else if (in_n[g])    seen_q <= '0;
      else if (seen_q != LIM_V) seen_q <= seen_q + 1'b1;
    end

    AST_IDLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      in_n[g] |-> (out_n[g] && !tmo_flag[g])); // R2
    AST_DOM_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_n[g] && seen_q != LIM_V) |-> !out_n[g]); // R3
    AST_TIMEOUT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_n[g] && seen_q == LIM_V) |-> (out_n[g] && tmo_flag[g])); // R4
    AST_FORCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_flag[g] && !in_n[g]) |=> (in_n[g] || tmo_flag[g])); // R5
    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_flag[g] |-> chan_expired[g]); // R6
  end
endmodule

bind dom_timeout_guard dg_guard_checker #(
  .NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ), .TIMEOUT_US(TIMEOUT_US)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_n         (in_n),
  .out_n        (out_n),
  .tmo_flag     (tmo_flag),
  .chan_expired (chan_expired)
);

// File: tb/tb_dom_timeout_guard.sv
module tb_dom_timeout_guard;
  localparam int NCH = 4;
  // 1.5 clocks per microsecond times 13 us is 19.5, rounded up to 20 (R8).
  localparam int EXP_LIMIT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] in_n = '0;
  logic [NCH-1:0] out_n;
  logic [NCH-1:0] tmo_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dom_timeout_guard #(.NUM_CH(NCH), .CLK_HZ(1_500_000), .TIMEOUT_US(13)) dut (
    .clk(clk), .rst_n(rst_n), .in_n(in_n), .out_n(out_n), .tmo_flag(tmo_flag)
  );

  // {in_n, edges, expected out_n, expected tmo_flag}
  localparam int NV = 17;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1111, 8'd2,  4'b1111, 4'b0000}, // R2 idle
    {4'b1110, 8'd5,  4'b1110, 4'b0000}, // R3 ch0 run 5
    {4'b1100, 8'd10, 4'b1100, 4'b0000}, // R3 R7 ch0 15, ch1 10
    {4'b1100, 8'd4,  4'b1100, 4'b0000}, // R3 R8 ch0 at 19 still passes
    {4'b1100, 8'd1,  4'b1101, 4'b0001}, // R4 R8 ch0 at 20 overridden
    {4'b0100, 8'd5,  4'b0111, 4'b0011}, // R5 R7 ch0 held, ch1 at 20
    {4'b0101, 8'd1,  4'b0111, 4'b0010}, // R6 R7 ch0 released
    {4'b0100, 8'd3,  4'b0110, 4'b0010}, // R6 ch0 fresh window
    {4'b1111, 8'd1,  4'b1111, 4'b0000}, // R2 all clear
    {4'b0000, 8'd19, 4'b0000, 4'b0000}, // R3 all at 19
    {4'b0000, 8'd1,  4'b1111, 4'b1111}, // R4 all at 20
    {4'b1111, 8'd1,  4'b1111, 4'b0000}, // R6 clear
    {4'b0000, 8'd0,  4'b0000, 4'b0000}, // R3 no-edge pass-through
    {4'b0000, 8'd20, 4'b1111, 4'b1111}, // R4 full window
    {4'b1111, 8'd0,  4'b1111, 4'b0000}, // R6 flag drops at once
    {4'b0000, 8'd0,  4'b1111, 4'b1111}, // R6 no edge saw recessive
    {4'b1111, 8'd1,  4'b1111, 4'b0000}  // R6 clear
  };

  task automatic check(input string req, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit align;
    // R1: reset state with all inputs dominant
    #1;
    check("R1", "out_n in reset", out_n, 4'b1111);
    check("R1", "tmo_flag in reset", tmo_flag, 4'b0000);
    @(negedge clk);
    in_n = '1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    align = 1'b1;
    for (int i = 0; i < NV; i++) begin
      if (align) @(negedge clk);
      in_n = VEC[i][19:16];
      if (VEC[i][15:8] == 0) begin
        #1;
        align = 1'b0;
      end else begin
        repeat (int'(VEC[i][15:8])) @(posedge clk);
        #2;
        align = 1'b1;
      end
      check("R2-R8 vec", $sformatf("out_n row %0d", i), out_n, VEC[i][7:4]);
      check("R2-R8 vec", $sformatf("tmo_flag row %0d", i), tmo_flag, VEC[i][3:0]);
    end

    // R1: reset in the middle of a run clears the count
    @(negedge clk);
    in_n = '0;
    repeat (15) @(posedge clk);
    #2;
    check("R3", "out_n before reset", out_n, 4'b0000);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "out_n mid-run reset", out_n, 4'b1111);
    check("R1", "tmo_flag mid-run reset", tmo_flag, 4'b0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (EXP_LIMIT - 1) @(posedge clk);
    #2;
    check("R1", "count restarted after reset", out_n, 4'b0000);
    @(posedge clk);
    #2;
    check("R4", "override after restarted window", out_n, 4'b1111);
    check("R4", "flag after restarted window", tmo_flag, 4'b1111);
    // R5: long hold well past the limit, no wrap
    repeat (3 * EXP_LIMIT) @(posedge clk);
    #2;
    check("R5", "out_n after long hold", out_n, 4'b1111);
    check("R5", "tmo_flag after long hold", tmo_flag, 4'b1111);
    finish_run();
  end
endmodule